// File: doc/BRIEF.md
# Cache-Side Directory Coherence Controller

This block is the coherence engine for one processor's cache in a multiprocessor whose memory is kept consistent by per-node home directories rather than by a shared bus. It holds a small direct-mapped array of lines. Each line carries a tag, one data word and a coherence state, which is Invalid, Shared (readable) or Exclusive (readable and writable). Processor loads and stores that hit are served in the cycle they are presented. Any other access blocks the processor, sends miss traffic to the home directory and waits for the data reply.

The block also answers the directory. An invalidate removes a readable copy. A fetch makes an owned copy go back to the directory with its data and drops the line to Shared. A fetch-with-invalidate does the same but drops the line to Invalid. When a miss lands on a slot that holds an owned line with another tag, the owned data is written back to its home before the miss message is sent. Every outgoing message carries this node's id, the block address and, for write-backs, the data word. The network is assumed to accept one message per cycle without back-pressure and to deliver messages in the order they were sent.

Top module: `coh_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, no message is sent, and the processor is not stalled while it presents no request.
- R2: A read whose line is Invalid or holds another tag stalls the processor. One cycle after the request is presented (with no victim write-back), the block sends a read-miss message (kind code 1) carrying the node id and the requested address. After the reply the line is Shared.
- R3: A write whose line is Invalid, Shared or holds another tag is a write miss. It sends a write-miss message (kind code 2), and once the reply arrives the line is Exclusive and holds the written word.
- R4: A read hit on a Shared or Exclusive line, or a write hit on an Exclusive line, finishes in the cycle it is presented, with no stall and no message. A read returns the stored word.
- R5: An incoming invalidate (kind code 4) whose address matches a Shared line makes it Invalid. An invalidate whose tag does not match the line at that index has no effect.
- R6: An incoming fetch (kind code 5) that matches an Exclusive line sends, in the same cycle, a data write-back (kind code 3) with the line's address and data, and leaves the line Shared.
- R7: An incoming fetch-with-invalidate (kind code 6) that matches an Exclusive line sends the same write-back in the same cycle and leaves the line Invalid.
- R8: A miss to an index (the low IDX_W address bits) whose line is Exclusive with another tag first sends a write-back of that line, then the miss message one cycle later. The line ends Shared for a read and Exclusive for a write. A Shared victim is dropped without a message.
- R9: A miss completes only on a data reply (kind code 7). The stall drops in the cycle after the reply, and a read then returns the reply data. A reply that arrives while no miss is pending changes nothing.
- R10: A directory message presented in the same cycle as a processor request is handled first, and the processor is stalled for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until the cycle it is not stalled |
| cpu_wr | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | ADDR_W | Block address of the access |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid in a cycle with cpu_req high and cpu_stall low |
| cpu_stall | output | 1 | Processor must hold its request |
| dir_in_valid | input | 1 | Directory message present this cycle |
| dir_in_kind | input | 3 | Directory message kind (4, 5, 6 or 7) |
| dir_in_addr | input | ADDR_W | Block address of the directory message |
| dir_in_data | input | DATA_W | Data carried by a data reply |
| msg_out_valid | output | 1 | Outgoing message present this cycle |
| msg_out_kind | output | 3 | Outgoing message kind (1, 2 or 3) |
| msg_out_src | output | ID_W | Node id of this cache |
| msg_out_addr | output | ADDR_W | Block address of the outgoing message |
| msg_out_data | output | DATA_W | Write-back data |

## Verification
Hits and answers to directory messages are due in the cycle they are presented. So the bench drives each stimulus after a falling edge and samples the outputs one nanosecond later, before the next rising edge. A miss message is due one cycle after the request, or two cycles after it when a victim is written back first. The stall drops one cycle after the data reply. The bench therefore steps through a miss one falling edge at a time and checks the stall and the message outputs at each step. A message that appears early, late or twice makes a cycle's check fail.

// File: rtl/coh_pkg.sv
package coh_pkg;

   typedef enum logic [2:0] {
      MSG_NONE      = 3'd0,
      MSG_RD_MISS   = 3'd1,
      MSG_WR_MISS   = 3'd2,
      MSG_WRBACK    = 3'd3,
      MSG_INVAL     = 3'd4,
      MSG_FETCH     = 3'd5,
      MSG_FETCH_INV = 3'd6,
      MSG_DATA      = 3'd7
   } coh_msg_e;

   typedef enum logic [1:0] {
      LN_INV = 2'd0,
      LN_SHR = 2'd1,
      LN_EXC = 2'd2
   } line_st_e;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_WB   = 2'd1,
      FS_SEND = 2'd2,
      FS_WAIT = 2'd3
   } miss_st_e;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
   import coh_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int TAG_W  = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  ra_idx,
   output line_st_e          ra_st,
   output logic [TAG_W-1:0]  ra_tag,
   output logic [DATA_W-1:0] ra_data,
   input  logic [IDX_W-1:0]  rb_idx,
   output line_st_e          rb_st,
   output logic [TAG_W-1:0]  rb_tag,
   output logic [DATA_W-1:0] rb_data,
   input  logic              we,
   input  logic [IDX_W-1:0]  w_idx,
   input  line_st_e          w_st,
   input  logic [TAG_W-1:0]  w_tag,
   input  logic [DATA_W-1:0] w_data
);

   localparam int LINES = 1 << IDX_W;

   logic [LINES-1:0][1:0]        st_all;
   logic [LINES-1:0][TAG_W-1:0]  tag_all;
   logic [LINES-1:0][DATA_W-1:0] data_all;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      line_st_e          st_q;
      logic [TAG_W-1:0]  tag_q;
      logic [DATA_W-1:0] data_q;
      logic              hit_w;

      assign hit_w = we && (w_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     st_q <= LN_INV;
         else if (hit_w) st_q <= w_st;
      end

      always_ff @(posedge clk) begin
         if (hit_w) begin
            tag_q  <= w_tag;
            data_q <= w_data;
         end
      end

      assign st_all[i]   = st_q;
      assign tag_all[i]  = tag_q;
      assign data_all[i] = data_q;
   end

   assign ra_st   = line_st_e'(st_all[ra_idx]);
   assign ra_tag  = tag_all[ra_idx];
   assign ra_data = data_all[ra_idx];
   assign rb_st   = line_st_e'(st_all[rb_idx]);
   assign rb_tag  = tag_all[rb_idx];
   assign rb_data = data_all[rb_idx];

endmodule

// File: rtl/coh_dir_resp.sv
module coh_dir_resp
   import coh_pkg::*;
(
   input  logic     in_valid,
   input  coh_msg_e in_kind,
   input  line_st_e line_st,
   input  logic     tag_match,
   output logic     upd,
   output line_st_e new_st,
   output logic     send_wb
);

   always_comb begin
      upd     = 1'b0;
      new_st  = line_st;
      send_wb = 1'b0;
      if (in_valid && tag_match) begin
         unique case (in_kind)
            MSG_INVAL: begin
               if (line_st == LN_SHR) begin
                  upd    = 1'b1;
                  new_st = LN_INV;
               end
            end
            MSG_FETCH: begin
               if (line_st == LN_EXC) begin
                  upd     = 1'b1;
                  new_st  = LN_SHR;
                  send_wb = 1'b1;
               end
            end
            MSG_FETCH_INV: begin
               if (line_st == LN_EXC) begin
                  upd     = 1'b1;
                  new_st  = LN_INV;
                  send_wb = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/coh_cache_ctrl.sv
module coh_cache_ctrl
   import coh_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 4,
   parameter int DATA_W = 32,
   parameter int ID_W   = 4,
   parameter int MY_ID  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_stall,
   input  logic              dir_in_valid,
   input  logic [2:0]        dir_in_kind,
   input  logic [ADDR_W-1:0] dir_in_addr,
   input  logic [DATA_W-1:0] dir_in_data,
   output logic              msg_out_valid,
   output logic [2:0]        msg_out_kind,
   output logic [ID_W-1:0]   msg_out_src,
   output logic [ADDR_W-1:0] msg_out_addr,
   output logic [DATA_W-1:0] msg_out_data
);

   localparam int TAG_W = ADDR_W - IDX_W;

   initial begin
      if (IDX_W < 1 || IDX_W >= ADDR_W) $error("coh_cache_ctrl: IDX_W must be in 1..ADDR_W-1");
      if (ID_W < 1 || MY_ID < 0 || MY_ID >= (1 << ID_W)) $error("coh_cache_ctrl: MY_ID does not fit ID_W");
      if (DATA_W < 1) $error("coh_cache_ctrl: DATA_W must be positive");
   end

   miss_st_e          fsm_q, fsm_d;
   logic [ADDR_W-1:0] req_addr_q;
   logic              req_wr_q;
   logic [DATA_W-1:0] req_wdata_q;

   coh_msg_e          in_kind;
   logic [ADDR_W-1:0] cur_addr;
   logic [IDX_W-1:0]  cur_idx, dir_idx;
   logic [TAG_W-1:0]  cur_tag, dir_tag;

   line_st_e          a_st, b_st;
   logic [TAG_W-1:0]  a_tag, b_tag;
   logic [DATA_W-1:0] a_data, b_data;

   logic              dir_hit, resp_upd, resp_wb;
   line_st_e          resp_st;
   logic              tag_hit, hit_ok, idle_go, victim_exc, reply_now;

   logic              we;
   logic [IDX_W-1:0]  w_idx;
   line_st_e          w_st;
   logic [TAG_W-1:0]  w_tag;
   logic [DATA_W-1:0] w_data;

   assign in_kind  = coh_msg_e'(dir_in_kind);
   assign cur_addr = (fsm_q == FS_IDLE) ? cpu_addr : req_addr_q;
   assign cur_idx  = cur_addr[IDX_W-1:0];
   assign cur_tag  = cur_addr[ADDR_W-1:IDX_W];
   assign dir_idx  = dir_in_addr[IDX_W-1:0];
   assign dir_tag  = dir_in_addr[ADDR_W-1:IDX_W];

   coh_line_store #(
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
   ) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_idx  (cur_idx),
      .ra_st   (a_st),
      .ra_tag  (a_tag),
      .ra_data (a_data),
      .rb_idx  (dir_idx),
      .rb_st   (b_st),
      .rb_tag  (b_tag),
      .rb_data (b_data),
      .we      (we),
      .w_idx   (w_idx),
      .w_st    (w_st),
      .w_tag   (w_tag),
      .w_data  (w_data)
   );

   assign dir_hit = (b_st != LN_INV) && (b_tag == dir_tag);

   coh_dir_resp i_resp (
      .in_valid  (dir_in_valid),
      .in_kind   (in_kind),
      .line_st   (b_st),
      .tag_match (dir_hit),
      .upd       (resp_upd),
      .new_st    (resp_st),
      .send_wb   (resp_wb)
   );

   assign tag_hit    = (a_st != LN_INV) && (a_tag == cur_tag);
   assign hit_ok     = tag_hit && ((a_st == LN_EXC) || !cpu_wr);
   assign idle_go    = (fsm_q == FS_IDLE) && cpu_req && !dir_in_valid;
   assign victim_exc = (a_st == LN_EXC) && (a_tag != cur_tag);
   assign reply_now  = (fsm_q == FS_WAIT) && dir_in_valid && (in_kind == MSG_DATA);

   assign cpu_stall  = cpu_req && !(idle_go && hit_ok);
   assign cpu_rdata  = a_data;

   // outgoing message: a directory-requested write-back wins the cycle
   always_comb begin
      msg_out_valid = 1'b0;
      msg_out_kind  = 3'(MSG_NONE);
      msg_out_addr  = cur_addr;
      msg_out_data  = a_data;
      if (resp_wb) begin
         msg_out_valid = 1'b1;
         msg_out_kind  = 3'(MSG_WRBACK);
         msg_out_addr  = dir_in_addr;
         msg_out_data  = b_data;
      end else if (fsm_q == FS_WB && !dir_in_valid && victim_exc) begin
         msg_out_valid = 1'b1;
         msg_out_kind  = 3'(MSG_WRBACK);
         msg_out_addr  = {a_tag, cur_idx};
      end else if (fsm_q == FS_SEND && !dir_in_valid) begin
         msg_out_valid = 1'b1;
         msg_out_kind  = req_wr_q ? 3'(MSG_WR_MISS) : 3'(MSG_RD_MISS);
         msg_out_addr  = req_addr_q;
      end
   end
   assign msg_out_src = ID_W'(MY_ID);

   // single write port: directory updates, else the miss sequencer
   always_comb begin
      we     = 1'b0;
      w_idx  = cur_idx;
      w_st   = a_st;
      w_tag  = a_tag;
      w_data = a_data;
      if (resp_upd) begin
         we     = 1'b1;
         w_idx  = dir_idx;
         w_st   = resp_st;
         w_tag  = b_tag;
         w_data = b_data;
      end else if (idle_go && hit_ok && cpu_wr) begin
         we     = 1'b1;
         w_st   = LN_EXC;
         w_data = cpu_wdata;
      end else if ((fsm_q == FS_WB || fsm_q == FS_SEND) && !dir_in_valid) begin
         we     = (fsm_q == FS_SEND) || victim_exc;
         w_st   = LN_INV;
      end else if (reply_now) begin
         we     = 1'b1;
         w_st   = req_wr_q ? LN_EXC : LN_SHR;
         w_tag  = cur_tag;
         w_data = req_wr_q ? req_wdata_q : dir_in_data;
      end
   end

   always_comb begin
      fsm_d = fsm_q;
      unique case (fsm_q)
         FS_IDLE: if (idle_go && !hit_ok) fsm_d = (a_st == LN_EXC) ? FS_WB : FS_SEND;
         FS_WB:   if (!dir_in_valid) fsm_d = FS_SEND;
         FS_SEND: if (!dir_in_valid) fsm_d = FS_WAIT;
         FS_WAIT: if (reply_now) fsm_d = FS_IDLE;
         default: fsm_d = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsm_q       <= FS_IDLE;
         req_addr_q  <= '0;
         req_wr_q    <= 1'b0;
         req_wdata_q <= '0;
      end else begin
         fsm_q <= fsm_d;
         if (idle_go && !hit_ok) begin
            req_addr_q  <= cpu_addr;
            req_wr_q    <= cpu_wr;
            req_wdata_q <= cpu_wdata;
         end
      end
   end

endmodule

// File: rtl/coh_cache_ctrl_chk.sv
module coh_cache_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_req,
   input logic       cpu_stall,
   input logic       dir_in_valid,
   input logic       msg_out_valid,
   input logic [2:0] msg_out_kind,
   input logic [1:0] fsm_st
);

   // R1
   out_kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_out_valid |-> (msg_out_kind == 3'd1 || msg_out_kind == 3'd2 || msg_out_kind == 3'd3));

   // R4
   hit_is_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_stall) |-> !msg_out_valid);

   // R8
   wb_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_st == 2'd1 && msg_out_valid && msg_out_kind == 3'd3 && !dir_in_valid) |=> (fsm_st == 2'd2));

   // R9
   busy_blocks_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_st != 2'd0 && cpu_req) |-> cpu_stall);

   // R10
   dir_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && dir_in_valid) |-> cpu_stall);

   // R2
   miss_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_st == 2'd2 && !dir_in_valid) |=> (fsm_st == 2'd3));

endmodule

bind coh_cache_ctrl coh_cache_ctrl_chk i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_req       (cpu_req),
   .cpu_stall     (cpu_stall),
   .dir_in_valid  (dir_in_valid),
   .msg_out_valid (msg_out_valid),
   .msg_out_kind  (msg_out_kind),
   .fsm_st        (fsm_q)
);

// File: tb/test_coh_cache_ctrl.sv
`timescale 1ns/1ps
module test_coh_cache_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_wr = 1'b0;
   logic [11:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_stall;
   logic        dir_in_valid = 1'b0;
   logic [2:0]  dir_in_kind = '0;
   logic [11:0] dir_in_addr = '0;
   logic [31:0] dir_in_data = '0;
   logic        msg_out_valid;
   logic [2:0]  msg_out_kind;
   logic [3:0]  msg_out_src;
   logic [11:0] msg_out_addr;
   logic [31:0] msg_out_data;

   int nchk = 0, nerr = 0, cyc = 0;

   localparam logic [11:0] A = 12'h120, B = 12'h340, C = 12'h055;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   coh_cache_ctrl #(.ADDR_W(12), .IDX_W(4), .DATA_W(32), .ID_W(4), .MY_ID(3)) i_coh_cache_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
      .dir_in_valid(dir_in_valid), .dir_in_kind(dir_in_kind), .dir_in_addr(dir_in_addr),
      .dir_in_data(dir_in_data), .msg_out_valid(msg_out_valid), .msg_out_kind(msg_out_kind),
      .msg_out_src(msg_out_src), .msg_out_addr(msg_out_addr), .msg_out_data(msg_out_data));

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic chk_msg(input string rq, input logic [2:0] kind, input logic [11:0] a, input logic [31:0] d, input bit has_data);
      chk(rq, "msg valid", 32'(msg_out_valid), 32'd1);
      chk(rq, "msg kind", 32'(msg_out_kind), 32'(kind));
      chk(rq, "msg src", 32'(msg_out_src), 32'd3);
      chk(rq, "msg addr", 32'(msg_out_addr), 32'(a));
      if (has_data) chk(rq, "msg data", msg_out_data, d);
   endtask

   // one processor access; if miss, walk the message sequence and supply the reply
   task automatic access(input string rq, input bit wr, input logic [11:0] a, input logic [31:0] wd,
                         input bit miss, input bit wb, input logic [11:0] wb_a, input logic [31:0] wb_d,
                         input logic [31:0] reply, input logic [31:0] exp_rd);
      @(negedge clk);
      cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
      #1;
      if (!miss) begin
         chk(rq, "hit stall", 32'(cpu_stall), 32'd0);
         chk(rq, "hit no msg", 32'(msg_out_valid), 32'd0);
         if (!wr) chk(rq, "hit rdata", cpu_rdata, exp_rd);
      end else begin
         chk(rq, "miss stall", 32'(cpu_stall), 32'd1);
         chk(rq, "no msg in request cycle", 32'(msg_out_valid), 32'd0);
         if (wb) begin
            @(negedge clk); #1;
            chk_msg(rq, 3'd3, wb_a, wb_d, 1'b1);
         end
         @(negedge clk); #1;
         chk_msg(rq, wr ? 3'd2 : 3'd1, a, '0, 1'b0);
         chk(rq, "stall during send", 32'(cpu_stall), 32'd1);
         @(negedge clk);
         dir_in_valid = 1'b1; dir_in_kind = 3'd7; dir_in_addr = a; dir_in_data = reply;
         #1;
         chk("R9", "stall in reply cycle", 32'(cpu_stall), 32'd1);
         chk(rq, "no msg in reply cycle", 32'(msg_out_valid), 32'd0);
         @(negedge clk);
         dir_in_valid = 1'b0;
         #1;
         chk("R9", "stall released after reply", 32'(cpu_stall), 32'd0);
         chk(rq, "no msg after fill", 32'(msg_out_valid), 32'd0);
         chk("R9", "data after fill", cpu_rdata, wr ? wd : reply);
      end
      @(negedge clk);
      cpu_req = 1'b0;
   endtask

   task automatic dir_msg(input string rq, input logic [2:0] kind, input logic [11:0] a,
                          input bit exp_wb, input logic [31:0] wb_d);
      @(negedge clk);
      dir_in_valid = 1'b1; dir_in_kind = kind; dir_in_addr = a; dir_in_data = 32'hDEAD_BEEF;
      #1;
      if (exp_wb) chk_msg(rq, 3'd3, a, wb_d, 1'b1);
      else chk(rq, "no response msg", 32'(msg_out_valid), 32'd0);
      @(negedge clk);
      dir_in_valid = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      chk("R1", "reset stall", 32'(cpu_stall), 32'd0);
      chk("R1", "reset msg", 32'(msg_out_valid), 32'd0);
   endtask

   task automatic t_read_paths();
      access("R2", 1'b0, A, '0, 1'b1, 1'b0, '0, '0, 32'hAAAA_0001, '0);   // first read after reset misses (R1)
      access("R4", 1'b0, A, '0, 1'b0, 1'b0, '0, '0, '0, 32'hAAAA_0001);
      dir_msg("R9", 3'd7, A, 1'b0, '0);                                    // stray reply
      access("R9", 1'b0, A, '0, 1'b0, 1'b0, '0, '0, '0, 32'hAAAA_0001);
   endtask

   task automatic t_write_paths();
      access("R3", 1'b1, A, 32'h11, 1'b1, 1'b0, '0, '0, 32'h999, '0);      // Shared -> write miss
      access("R4", 1'b1, A, 32'h22, 1'b0, 1'b0, '0, '0, '0, '0);
      access("R4", 1'b0, A, '0, 1'b0, 1'b0, '0, '0, '0, 32'h22);
   endtask

   task automatic t_fetch();
      dir_msg("R6", 3'd5, A, 1'b1, 32'h22);
      access("R6", 1'b0, A, '0, 1'b0, 1'b0, '0, '0, '0, 32'h22);          // still readable
      access("R6", 1'b1, A, 32'h33, 1'b1, 1'b0, '0, '0, 32'h5, '0);       // no longer writable
   endtask

   task automatic t_fetch_inv();
      dir_msg("R7", 3'd6, A, 1'b1, 32'h33);
      access("R7", 1'b0, A, '0, 1'b1, 1'b0, '0, '0, 32'h44, '0);
   endtask

   task automatic t_invalidate();
      dir_msg("R5", 3'd4, B, 1'b0, '0);                                    // other tag: no effect
      access("R5", 1'b0, A, '0, 1'b0, 1'b0, '0, '0, '0, 32'h44);
      dir_msg("R5", 3'd4, A, 1'b0, '0);
      access("R5", 1'b0, A, '0, 1'b1, 1'b0, '0, '0, 32'h55, '0);
   endtask

   task automatic t_evict();
      access("R3", 1'b1, A, 32'h66, 1'b1, 1'b0, '0, '0, 32'h1, '0);
      access("R8", 1'b0, B, '0, 1'b1, 1'b1, A, 32'h66, 32'h77, '0);
      access("R8", 1'b0, B, '0, 1'b0, 1'b0, '0, '0, '0, 32'h77);
      access("R8", 1'b0, A, '0, 1'b1, 1'b0, '0, '0, 32'h88, '0);          // Shared victim dropped
      access("R8", 1'b1, B, 32'h99, 1'b1, 1'b0, '0, '0, 32'h2, '0);
      access("R8", 1'b1, A, 32'hAB, 1'b1, 1'b1, B, 32'h99, 32'h3, '0);
      access("R8", 1'b1, A, 32'hAC, 1'b0, 1'b0, '0, '0, '0, '0);
   endtask

   task automatic t_priority();
      @(negedge clk);
      cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = A;
      dir_in_valid = 1'b1; dir_in_kind = 3'd4; dir_in_addr = C;
      #1;
      chk("R10", "stall while directory message", 32'(cpu_stall), 32'd1);
      @(negedge clk);
      dir_in_valid = 1'b0;
      #1;
      chk("R10", "served next cycle", 32'(cpu_stall), 32'd0);
      chk("R10", "rdata next cycle", cpu_rdata, 32'hAC);
      @(negedge clk);
      cpu_req = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_read_paths();
      t_write_paths();
      t_fetch();
      t_fetch_inv();
      t_invalidate();
      t_evict();
      t_priority();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      wait (cyc >= 20000);
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

endmodule